// File: doc/BRIEF.md
# Lock-Step Instruction Sequencer

This block is the one control unit that steers four lock-step processing lanes. It holds the program counter and the instruction register, and it fetches 32-bit instruction words from a single memory of 16K words. The same memory holds both code and data. Each fetched word is split into an opcode and three operand fields, which go to every lane at once. The sequencer resolves the three branch forms itself, and it issues the one memory access that a load or store instruction is allowed. It stops for good when it executes a stop instruction.

Each instruction moves through three named states: FETCH, DECODE and EXEC. Instructions that read memory into the lanes add a fourth state, WB. The transitions are as follows:
- FETCH to DECODE.
- DECODE to EXEC.
- EXEC to FETCH for most opcodes.
- EXEC to WB for loads.
- WB to FETCH.
- EXEC to HALT for a stop instruction.
- HALT to HALT until reset.

Conditional branches look at a zero flag from each lane for the register under test. An indexed access takes its address from the effective address computed by the one lane that the instruction names.

Top module: `simd_seq`

## Requirements
- R1: During and right after reset the block is in FETCH with PC 0. mem_addr is 0, mem_rd is 1, busy is 1, and halted and exec_stb are 0.
- R2: The instruction register splits as follows: op_code is bits 31:24, fld_a1 is bits 23:10, fld_a2 is bits 9:5 and fld_a3 is bits 4:0.
- R3: One instruction takes three cycles (FETCH, DECODE, EXEC), and exec_stb is high only in EXEC. The load opcodes LD 0x01, LDW 0x05 and LDX 0x03 take a fourth cycle, WB. In WB, wb_stb is high and mem_rdata carries the word read in EXEC.
- R4: JMP (0x20) loads PC with fld_a1 unconditionally.
- R5: JZ (0x21) loads PC with fld_a1 only when all four lane_zero bits are 1. Otherwise PC advances by one.
- R6: JNZ (0x22) loads PC with fld_a1 only when all four lane_zero bits are 0. For mixed flags PC advances by one.
- R7: LD, LDW (reads) and ST (0x02, write) access address fld_a1 in EXEC.
- R8: LDX (0x03, read) and STX (0x04, write) take their address from the lane selected by fld_a1[1:0]. lane_ea holds lane k in bits 32k+31:32k, and only its low 14 bits are used.
- R9: SYS (0x3F) with fld_a1 equal to 4 halts. SYS with any other argument only advances PC.
- R10: Once halted, the block holds halted at 1 and busy at 0, keeps PC at the address of the stop instruction, and makes no memory access until reset.
- R11: Opcodes other than the five memory opcodes drive neither mem_rd nor mem_wr in EXEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 14 | Memory word address |
| mem_rd | output | 1 | Read request; data returns the next cycle |
| mem_wr | output | 1 | Write request (lanes supply the data) |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| lane_ea | input | 128 | Per-lane effective address sums, lane k in bits 32k+31:32k |
| lane_zero | input | 4 | Per-lane zero flag of the tested register |
| op_code | output | 8 | Opcode field of the current instruction |
| fld_a1 | output | 14 | Address, immediate, lane or register field |
| fld_a2 | output | 5 | First register field |
| fld_a3 | output | 5 | Second register field |
| exec_stb | output | 1 | High in the execute cycle |
| wb_stb | output | 1 | High in the load write-back cycle |
| pc_out | output | 14 | Program counter |
| busy | output | 1 | Running |
| halted | output | 1 | Stopped by a stop instruction |

## Verification
A wrong state or a wrong PC shows up at the very next exec_stb. It appears as an unexpected pc_out, a gap between strobes other than three or four cycles, or a missing or extra memory strobe in that cycle. A mis-resolved branch is visible within one instruction, because the next executed PC differs. The all-lanes rule is swept over all sixteen flag patterns for both conditional forms. A lost halt shows within one cycle as busy staying high and mem_rd pulsing again.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_WB     = 3'd3,
        ST_HALT   = 3'd4
    } seq_state_t;

    localparam logic [7:0] OP_LD   = 8'h01;
    localparam logic [7:0] OP_ST   = 8'h02;
    localparam logic [7:0] OP_LDX  = 8'h03;
    localparam logic [7:0] OP_STX  = 8'h04;
    localparam logic [7:0] OP_LDW  = 8'h05;
    localparam logic [7:0] OP_JMP  = 8'h20;
    localparam logic [7:0] OP_JZ   = 8'h21;
    localparam logic [7:0] OP_JNZ  = 8'h22;
    localparam logic [7:0] OP_SYS  = 8'h3F;
    localparam int         STOP_ARG = 4;

    function automatic logic op_reads(input logic [7:0] op);
        return (op == OP_LD) || (op == OP_LDW) || (op == OP_LDX);
    endfunction

    function automatic logic op_writes(input logic [7:0] op);
        return (op == OP_ST) || (op == OP_STX);
    endfunction

    function automatic logic op_indexed(input logic [7:0] op);
        return (op == OP_LDX) || (op == OP_STX);
    endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode #(
    parameter int DW  = 32,
    parameter int OPW = 8,
    parameter int RW  = 5,
    localparam int A1W = DW - OPW - 2 * RW
) (
    input  logic [DW-1:0]  ir,
    output logic [OPW-1:0] op,
    output logic [A1W-1:0] a1,
    output logic [RW-1:0]  a2,
    output logic [RW-1:0]  a3
);
    localparam int A3_LO = 0;
    localparam int A2_LO = RW;
    localparam int A1_LO = 2 * RW;
    localparam int OP_LO = DW - OPW;

    always_comb begin
        op = ir[OP_LO +: OPW];
        a1 = ir[A1_LO +: A1W];
        a2 = ir[A2_LO +: RW];
        a3 = ir[A3_LO +: RW];
    end
endmodule

// File: rtl/seq_branch.sv
module seq_branch #(
    parameter int AW    = 14,
    parameter int OPW   = 8,
    parameter int LANES = 4
) (
    input  logic [OPW-1:0]   op,
    input  logic [AW-1:0]    target,
    input  logic [AW-1:0]    pc,
    input  logic [LANES-1:0] lane_zero,
    output logic [AW-1:0]    pc_next
);
    import seq_pkg::*;

    logic all_zero;
    logic none_zero;
    logic [AW-1:0] pc_inc;

    always_comb begin
        all_zero  = &lane_zero;
        none_zero = ~|lane_zero;
        pc_inc    = pc + AW'(1);
        if (op == OP_JMP)
            pc_next = target;
        else if (op == OP_JZ)
            pc_next = all_zero ? target : pc_inc;
        else if (op == OP_JNZ)
            pc_next = none_zero ? target : pc_inc;
        else
            pc_next = pc_inc;
    end
endmodule

// File: rtl/seq_ea_mux.sv
module seq_ea_mux #(
    parameter int DW    = 32,
    parameter int AW    = 14,
    parameter int LANES = 4,
    localparam int LSW  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES*DW-1:0] lane_ea,
    input  logic [LSW-1:0]      sel,
    output logic [AW-1:0]       ea
);
    logic [AW-1:0] trunc [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign trunc[k] = lane_ea[k*DW +: AW];
    end

    always_comb begin
        ea = '0;
        for (int k = 0; k < LANES; k++)
            if (sel == LSW'(k)) ea = trunc[k];
    end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm #(
    parameter int OPW = 8,
    parameter int A1W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op,
    input  logic [A1W-1:0] a1,
    output logic           fetch,
    output logic           ir_load,
    output logic           exec,
    output logic           wb,
    output logic           pc_load,
    output logic           stopped
);
    import seq_pkg::*;

    seq_state_t state, state_nx;
    logic stop_op;

    assign stop_op = (op == OP_SYS) && (a1 == A1W'(STOP_ARG));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: state_nx = ST_EXEC;
            ST_EXEC: begin
                if (stop_op)          state_nx = ST_HALT;
                else if (op_reads(op)) state_nx = ST_WB;
                else                  state_nx = ST_FETCH;
            end
            ST_WB:     state_nx = ST_FETCH;
            ST_HALT:   state_nx = ST_HALT;
            default:   state_nx = ST_FETCH;
        endcase
    end

    always_comb begin
        fetch   = 1'b0;
        ir_load = 1'b0;
        exec    = 1'b0;
        wb      = 1'b0;
        pc_load = 1'b0;
        stopped = 1'b0;
        unique case (state)
            ST_FETCH:  fetch = 1'b1;
            ST_DECODE: ir_load = 1'b1;
            ST_EXEC: begin
                exec    = 1'b1;
                pc_load = !stop_op;
            end
            ST_WB:     wb = 1'b1;
            ST_HALT:   stopped = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/simd_seq.sv
module simd_seq #(
    parameter int AW    = 14,
    parameter int DW    = 32,
    parameter int OPW   = 8,
    parameter int RW    = 5,
    parameter int LANES = 4,
    localparam int A1W  = DW - OPW - 2 * RW
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    input  logic [DW-1:0]       mem_rdata,
    input  logic [LANES*DW-1:0] lane_ea,
    input  logic [LANES-1:0]    lane_zero,
    output logic [OPW-1:0]      op_code,
    output logic [A1W-1:0]      fld_a1,
    output logic [RW-1:0]       fld_a2,
    output logic [RW-1:0]       fld_a3,
    output logic                exec_stb,
    output logic                wb_stb,
    output logic [AW-1:0]       pc_out,
    output logic                busy,
    output logic                halted
);
    import seq_pkg::*;

    localparam int LSW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [AW-1:0] pc_q;
    logic [DW-1:0] ir_q;
    logic [AW-1:0] pc_nx;
    logic [AW-1:0] ea;
    logic [AW-1:0] a1_addr;
    logic fetch, ir_load, exec, wb, pc_load, stopped;

    assign a1_addr = fld_a1[AW-1:0];

    seq_decode #(.DW(DW), .OPW(OPW), .RW(RW)) u_dec (
        .ir (ir_q),
        .op (op_code),
        .a1 (fld_a1),
        .a2 (fld_a2),
        .a3 (fld_a3)
    );

    seq_fsm #(.OPW(OPW), .A1W(A1W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op_code),
        .a1      (fld_a1),
        .fetch   (fetch),
        .ir_load (ir_load),
        .exec    (exec),
        .wb      (wb),
        .pc_load (pc_load),
        .stopped (stopped)
    );

    seq_branch #(.AW(AW), .OPW(OPW), .LANES(LANES)) u_br (
        .op        (op_code),
        .target    (a1_addr),
        .pc        (pc_q),
        .lane_zero (lane_zero),
        .pc_next   (pc_nx)
    );

    seq_ea_mux #(.DW(DW), .AW(AW), .LANES(LANES)) u_ea (
        .lane_ea (lane_ea),
        .sel     (fld_a1[LSW-1:0]),
        .ea      (ea)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            if (ir_load) ir_q <= mem_rdata;
            if (pc_load) pc_q <= pc_nx;
        end
    end

    always_comb begin
        mem_rd   = fetch || (exec && op_reads(op_code));
        mem_wr   = exec && op_writes(op_code);
        if (fetch)                   mem_addr = pc_q;
        else if (op_indexed(op_code)) mem_addr = ea;
        else                         mem_addr = a1_addr;
    end

    assign exec_stb = exec;
    assign wb_stb   = wb;
    assign pc_out   = pc_q;
    assign halted   = stopped;
    assign busy     = !stopped;
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
    parameter int AW    = 14,
    parameter int OPW   = 8,
    parameter int A1W   = 14,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OPW-1:0]   op_code,
    input logic [A1W-1:0]   fld_a1,
    input logic [LANES-1:0] lane_zero,
    input logic             exec_stb,
    input logic             wb_stb,
    input logic [AW-1:0]    pc_out,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             halted
);
    import seq_pkg::*;

    // R3
    wb_follows_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> $past(exec_stb));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_stb && wb_stb) && !(mem_rd && mem_wr));

    // R4
    jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_code == OP_JMP) |=> (pc_out == $past(fld_a1[AW-1:0])));

    // R5
    jz_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_code == OP_JZ && !(&lane_zero)) |=> (pc_out == $past(pc_out) + AW'(1)));

    // R6
    jnz_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && op_code == OP_JNZ && (|lane_zero)) |=> (pc_out == $past(pc_out) + AW'(1)));

    // R10
    halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_out)));

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr && !exec_stb));
endmodule

bind simd_seq seq_chk #(.AW(AW), .OPW(OPW), .A1W(A1W), .LANES(LANES)) u_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_code   (op_code),
    .fld_a1    (fld_a1),
    .lane_zero (lane_zero),
    .exec_stb  (exec_stb),
    .wb_stb    (wb_stb),
    .pc_out    (pc_out),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .halted    (halted)
);

// File: tb/test_simd_seq.sv
module test_simd_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [13:0]  mem_addr;
    logic         mem_rd, mem_wr;
    logic [31:0]  mem_rdata = '0;
    logic [127:0] lane_ea;
    logic [3:0]   lane_zero = 4'b0101;
    logic [7:0]   op_code;
    logic [13:0]  fld_a1;
    logic [4:0]   fld_a2, fld_a3;
    logic         exec_stb, wb_stb, busy, halted;
    logic [13:0]  pc_out;
    logic [31:0]  mem [256];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    simd_seq i_simd_seq (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_rdata(mem_rdata), .lane_ea(lane_ea),
        .lane_zero(lane_zero), .op_code(op_code), .fld_a1(fld_a1),
        .fld_a2(fld_a2), .fld_a3(fld_a3), .exec_stb(exec_stb),
        .wb_stb(wb_stb), .pc_out(pc_out), .busy(busy), .halted(halted)
    );

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

    assign lane_ea = {32'hFFFF_C055, 32'h0007_003C, 32'd11, 32'd10};

    function automatic logic [31:0] ins(input logic [7:0] op, input logic [13:0] a1,
                                        input logic [4:0] a2, input logic [4:0] a3);
        return {op, a1, a2, a3};
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_exec(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!exec_stb && gap < 40);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int pc, input int gap_exp, input logic rd, input logic wr,
                        input int addr, input string tag);
        int gap;
        wait_exec(gap);
        chk(pc_out == 14'(pc), {tag, " pc"}, pc_out, pc);
        chk(gap == gap_exp, "R3 cycles per instruction", gap, gap_exp);
        chk(mem_rd == rd && mem_wr == wr, {tag, " strobes"}, {mem_rd, mem_wr}, {rd, wr});
        if (rd || wr) chk(mem_addr == 14'(addr), {tag, " address"}, mem_addr, addr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", pc_out);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = ins(8'h3F, 14'd4, 5'd0, 5'd0);
        mem[0]  = ins(8'h20, 14'd4, 0, 0);
        mem[4]  = ins(8'h01, 14'd100, 5'd1, 0);
        mem[5]  = ins(8'h02, 14'd101, 5'd2, 0);
        mem[6]  = ins(8'h05, 14'd102, 0, 0);
        mem[7]  = ins(8'h03, 14'd2, 5'd4, 5'd5);
        mem[8]  = ins(8'h04, 14'd3, 5'd4, 5'd5);
        mem[9]  = ins(8'h12, 14'h2A5C, 5'd7, 5'd9);
        mem[10] = ins(8'h21, 14'd40, 0, 0);
        mem[11] = ins(8'h22, 14'd40, 0, 0);
        mem[12] = ins(8'h3F, 14'd3, 0, 0);
        mem[13] = ins(8'h3F, 14'd4, 0, 0);
        mem[60]  = 32'hCAFE_0001;
        mem[100] = 32'hDEAD_BEEF;
        mem[102] = 32'h1234_5678;

        do_reset();
        #1;
        // R1 reset state
        chk(pc_out == 0 && mem_addr == 0 && mem_rd && busy && !halted && !exec_stb,
            "R1 reset state", {pc_out, mem_rd, busy, halted}, 16'h0001 << 2 | 16'h2);
        @(negedge clk);
        begin
            int gap;
            wait_exec(gap);
            chk(pc_out == 0 && gap == 1, "R3 first execute", gap, 1);
            chk(!mem_rd && !mem_wr, "R11 jmp no access", {mem_rd, mem_wr}, 0);
        end
        step(4, 3, 1, 0, 100, "R4 jmp then R7 ld");
        @(negedge clk);
        chk(wb_stb && mem_rdata == 32'hDEAD_BEEF, "R3 load write-back", mem_rdata, 32'hDEAD_BEEF);
        step(5, 3, 0, 1, 101, "R7 st");
        step(6, 3, 1, 0, 102, "R7 ldw");
        @(negedge clk);
        chk(wb_stb && mem_rdata == 32'h1234_5678, "R7 ldw data", mem_rdata, 32'h1234_5678);
        step(7, 3, 1, 0, 60, "R8 ldx lane 2");
        @(negedge clk);
        chk(wb_stb && mem_rdata == 32'hCAFE_0001, "R8 ldx data", mem_rdata, 32'hCAFE_0001);
        step(8, 3, 0, 1, 14'h55, "R8 stx lane 3 truncated");
        step(9, 3, 0, 0, 0, "R11 alu op");
        // R2 field split
        chk(op_code == 8'h12 && fld_a1 == 14'h2A5C && fld_a2 == 7 && fld_a3 == 9,
            "R2 fields", {op_code, fld_a1, fld_a2, fld_a3}, {8'h12, 14'h2A5C, 5'd7, 5'd9});
        step(10, 3, 0, 0, 0, "R5 jz reached");
        step(11, 3, 0, 0, 0, "R5 jz mixed not taken");
        step(12, 3, 0, 0, 0, "R6 jnz mixed not taken");
        step(13, 3, 0, 0, 0, "R9 sys 3 no halt");
        @(negedge clk);
        chk(halted && !busy, "R9 sys 4 halts", {halted, busy}, 2'b10);
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mem_rd || mem_wr || exec_stb || !halted || pc_out != 13) seen++;
            end
            chk(seen == 0, "R10 frozen after halt", seen, 0);
        end

        // branch flag sweep: 0 JZ @10, 1 JNZ @20
        for (int i = 0; i < 256; i++) mem[i] = ins(8'h3F, 14'd4, 5'd0, 5'd0);
        mem[0] = ins(8'h21, 14'd10, 0, 0);
        mem[1] = ins(8'h22, 14'd20, 0, 0);
        for (int p = 0; p < 16; p++) begin
            int gap;
            int exp1;
            lane_zero = 4'(p);
            do_reset();
            wait_exec(gap);
            chk(pc_out == 0, "R5 sweep start", pc_out, 0);
            wait_exec(gap);
            exp1 = (p == 15) ? 10 : 1;
            chk(pc_out == 14'(exp1), "R5 jz all-lanes rule", pc_out, exp1);
            if (exp1 == 1) begin
                int exp2;
                wait_exec(gap);
                exp2 = (p == 0) ? 20 : 2;
                chk(pc_out == 14'(exp2), "R6 jnz all-lanes rule", pc_out, exp2);
            end
            @(negedge clk);
            chk(halted, "R9 sweep halt", halted, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule